// File: doc/BRIEF.md
# Dual-Rate FIFO Read Port

This block is the read side of a FIFO. It fetches words from the FIFO storage and drives them onto an output data register. It moves either one word per read-clock period (single rate) or one word on each half of the period (double rate). A read happens only when both the active-low read enable and the active-low chip select are low. The rate is fixed when the block leaves master reset.

The model runs on a clock at twice the read-clock frequency. An internal slot toggle marks which half of the read-clock period is current, and the derived read clock is brought out as `rclk_o`. The enables are sampled only at the end of a rising-half slot, so every burst starts on a rising edge. In double-rate mode the falling half only finishes a pair that the rising half started. The storage is outside the block: the port sends an address and gets the word back in the same cycle. The write pointer comes in with one wrap bit, and the port compares it against its own read pointer to decide when the FIFO is empty.

Top module: `rdp_read_port`

## Requirements
- R1: After master reset the data output is 0, the read address is 0 and `empty_o` is high exactly when `wr_ptr_i` equals the reset read pointer of 0.
- R2: The rate is taken from `ddr_sel_i` (1 = double rate, 0 = single rate) on the first `clk_i` edge after `rst_ni` rises. Later changes of `ddr_sel_i` have no effect until the next master reset.
- R3: In single-rate mode, each rising half with `ren_ni` and `rcs_ni` both low and the FIFO not empty loads the word at the read address into `dout_o` and advances the address by one. Falling halves never move data.
- R4: A rising half with `ren_ni` high or `rcs_ni` high reads nothing: `dout_o` holds its value and the address is unchanged.
- R5: In double-rate mode, one enabled rising half delivers two consecutive words. The first appears after the rising half and the second after the falling half that follows it.
- R6: In double-rate mode the enables are sampled only in rising halves. Enables that are low only during a falling half start no read.
- R7: In double-rate mode, if only one word remains, that word is delivered, `empty_o` goes high, and the read pointer stops at the write pointer.
- R8: While the FIFO is empty, enabled rising halves do not move the pointer and do not change `dout_o`.
- R9: While `part_rst_ni` is low, the read pointer and `dout_o` are cleared and the enables and chip select are ignored. The rate latched at master reset is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock at twice the read-clock rate |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| part_rst_ni | input | 1 | Active-low synchronous partial reset |
| ddr_sel_i | input | 1 | Rate select, latched when leaving master reset (1 = double) |
| ren_ni | input | 1 | Active-low read enable |
| rcs_ni | input | 1 | Active-low read chip select |
| wr_ptr_i | input | ADDR_W+1 | Write pointer with wrap bit |
| mem_raddr_o | output | ADDR_W | Storage read address |
| mem_rdata_i | input | DATA_W | Storage read data for `mem_raddr_o` (same cycle) |
| rclk_o | output | 1 | Derived read clock, high in the rising half |
| dout_o | output | DATA_W | Output data register |
| empty_o | output | 1 | FIFO empty indication |

## Verification
Single-rate reads are run as a back-to-back burst, a burst gated by the chip select alone, and a burst gated by the enable alone. This separates the AND of the two controls from a decode of just one of them. Double-rate reads are run as a single pair, a three-pair stream, and an enable held low only in a falling half. These show whether the second word comes from the falling half and whether falling-half enables are ignored. Draining to the last word, reading while empty, a second master reset with the rate pin changed afterwards, and a partial reset with the enables held low show the boundary handling and that the rate stays latched.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic {SLOT_RISE = 1'b0, SLOT_FALL = 1'b1} slot_e;
  typedef enum logic {RATE_SDR = 1'b0, RATE_DDR = 1'b1} rate_e;
endpackage

// File: rtl/rdp_phase.sv
module rdp_phase
  import rdp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ddr_sel_i,
  output rate_e rate_o,
  output logic  cfg_done_o,
  output slot_e slot_o
);
  logic  cfg_done_q;
  rate_e rate_q;
  slot_e slot_q;

  // rate captured on the first edge out of master reset, then frozen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_done_q <= 1'b0;
      rate_q     <= RATE_SDR;
    end else if (!cfg_done_q) begin
      cfg_done_q <= 1'b1;
      rate_q     <= ddr_sel_i ? RATE_DDR : RATE_SDR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         slot_q <= SLOT_RISE;
    else if (cfg_done_q) slot_q <= (slot_q == SLOT_RISE) ? SLOT_FALL : SLOT_RISE;
  end

  assign rate_o     = rate_q;
  assign cfg_done_o = cfg_done_q;
  assign slot_o     = slot_q;
endmodule

// File: rtl/rdp_rd_ctrl.sv
module rdp_rd_ctrl
  import rdp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  part_rst_ni,
  input  logic  cfg_done_i,
  input  slot_e slot_i,
  input  rate_e rate_i,
  input  logic  ren_ni,
  input  logic  rcs_ni,
  input  logic  empty_i,
  output logic  take_o
);
  logic pend_q;
  logic active;
  logic rise_take;
  logic fall_take;

  assign active    = cfg_done_i && part_rst_ni;
  assign rise_take = active && (slot_i == SLOT_RISE) && !ren_ni && !rcs_ni && !empty_i;
  // falling half only completes a pair opened by the preceding rising half
  assign fall_take = active && (slot_i == SLOT_FALL) && pend_q && !empty_i;
  assign take_o    = rise_take || fall_take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pend_q <= 1'b0;
    else if (!part_rst_ni)      pend_q <= 1'b0;
    else if (slot_i == SLOT_RISE) pend_q <= rise_take && (rate_i == RATE_DDR);
    else                        pend_q <= 1'b0;
  end
endmodule

// File: rtl/rdp_ptr.sv
module rdp_ptr #(
  parameter int ADDR_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            part_rst_ni,
  input  logic            take_i,
  input  logic [ADDR_W:0] wr_ptr_i,
  output logic [ADDR_W:0] rd_ptr_o,
  output logic            empty_o
);
  localparam int PTR_W = ADDR_W + 1;
  logic [PTR_W-1:0] rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rd_ptr_q <= '0;
    else if (!part_rst_ni) rd_ptr_q <= '0;
    else if (take_i)       rd_ptr_q <= rd_ptr_q + PTR_W'(1);
  end

  assign rd_ptr_o = rd_ptr_q;
  assign empty_o  = (rd_ptr_q == wr_ptr_i);
endmodule

// File: rtl/rdp_out_reg.sv
module rdp_out_reg #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              part_rst_ni,
  input  logic              take_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] dout_o
);
  logic [DATA_W-1:0] dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           dout_q <= '0;
    else if (!part_rst_ni) dout_q <= '0;
    else if (take_i)       dout_q <= rdata_i;
  end

  assign dout_o = dout_q;
endmodule

// File: rtl/rdp_read_port.sv
module rdp_read_port
  import rdp_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              part_rst_ni,
  input  logic              ddr_sel_i,
  input  logic              ren_ni,
  input  logic              rcs_ni,
  input  logic [ADDR_W:0]   wr_ptr_i,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rclk_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              empty_o
);
  slot_e           slot;
  rate_e           rate;
  logic            cfg_done;
  logic            take;
  logic            empty;
  logic [ADDR_W:0] rd_ptr;

  rdp_phase u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ddr_sel_i  (ddr_sel_i),
    .rate_o     (rate),
    .cfg_done_o (cfg_done),
    .slot_o     (slot)
  );

  rdp_rd_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .part_rst_ni (part_rst_ni),
    .cfg_done_i  (cfg_done),
    .slot_i      (slot),
    .rate_i      (rate),
    .ren_ni      (ren_ni),
    .rcs_ni      (rcs_ni),
    .empty_i     (empty),
    .take_o      (take)
  );

  rdp_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .part_rst_ni (part_rst_ni),
    .take_i      (take),
    .wr_ptr_i    (wr_ptr_i),
    .rd_ptr_o    (rd_ptr),
    .empty_o     (empty)
  );

  rdp_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .part_rst_ni (part_rst_ni),
    .take_i      (take),
    .rdata_i     (mem_rdata_i),
    .dout_o      (dout_o)
  );

  assign mem_raddr_o = rd_ptr[ADDR_W-1:0];
  assign empty_o     = empty;
  assign rclk_o      = cfg_done && (slot == SLOT_RISE);
endmodule

// File: rtl/rdp_read_port_chk.sv
module rdp_read_port_chk
  import rdp_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              part_rst_ni,
  input logic              cfg_done_i,
  input slot_e             slot_i,
  input rate_e             rate_i,
  input logic              take_i,
  input logic              empty_i,
  input logic [ADDR_W:0]   rd_ptr_i,
  input logic [DATA_W-1:0] dout_i
);
  p_rate_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_i |=> $stable(rate_i));

  p_ptr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> rd_ptr_i == $past(rd_ptr_i) + (ADDR_W+1)'(1));

  p_hold_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && part_rst_ni) |=> $stable(dout_i));

  p_fall_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && slot_i == SLOT_FALL) |-> (rate_i == RATE_DDR && $past(take_i)));

  p_no_overrun_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> !empty_i);

  p_prst_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !part_rst_ni |=> (dout_i == '0 && rd_ptr_i == '0));
endmodule

bind rdp_read_port rdp_read_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .part_rst_ni (part_rst_ni),
  .cfg_done_i  (cfg_done),
  .slot_i      (slot),
  .rate_i      (rate),
  .take_i      (take),
  .empty_i     (empty),
  .rd_ptr_i    (rd_ptr),
  .dout_i      (dout_o)
);

// File: tb/rdp_read_port_bench.sv
module rdp_read_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 10;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              part_rst_ni = 1'b1;
  logic              ddr_sel_i = 1'b0;
  logic              ren_ni = 1'b1;
  logic              rcs_ni = 1'b1;
  logic [ADDR_W:0]   wr_ptr_i = '0;
  logic [ADDR_W-1:0] mem_raddr_o;
  logic [DATA_W-1:0] mem_rdata_i;
  logic              rclk_o;
  logic [DATA_W-1:0] dout_o;
  logic              empty_o;

  logic [DATA_W-1:0] mem [DEPTH];
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  assign mem_rdata_i = mem[mem_raddr_o];

  rdp_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdp_read_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .part_rst_ni(part_rst_ni), .ddr_sel_i(ddr_sel_i),
    .ren_ni(ren_ni), .rcs_ni(rcs_ni), .wr_ptr_i(wr_ptr_i), .mem_raddr_o(mem_raddr_o),
    .mem_rdata_i(mem_rdata_i), .rclk_o(rclk_o), .dout_o(dout_o), .empty_o(empty_o)
  );

  function automatic logic [DATA_W-1:0] word(input int i);
    return DATA_W'(i * 41 + 7);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    @(negedge clk_i);
    while (!rclk_o) @(negedge clk_i);
  endtask

  task automatic master_reset(input logic ddr);
    @(negedge clk_i);
    rst_ni = 1'b0; ddr_sel_i = ddr; ren_ni = 1'b1; rcs_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    master_reset(1'b0);
    wr_ptr_i = '0;
    @(negedge clk_i);
    chk("R1 dout", int'(dout_o), 0);
    chk("R1 addr", int'(mem_raddr_o), 0);
    chk("R1 empty", int'(empty_o), 1);
    wr_ptr_i = 5'd6;
    #1 chk("R1 not empty", int'(empty_o), 0);
  endtask

  task automatic t_sdr_burst();
    wait_rise();
    ren_ni = 1'b0; rcs_ni = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk("R3 sdr word", int'(dout_o), int'(word(k)));
      @(negedge clk_i);
      chk("R3 fall no move", int'(dout_o), int'(word(k)));
      if (k == 2) begin ren_ni = 1'b1; rcs_ni = 1'b1; end
    end
    chk("R3 addr", int'(mem_raddr_o), 3);
  endtask

  task automatic t_gated();
    wait_rise();
    ren_ni = 1'b0; rcs_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R4 rcs high dout", int'(dout_o), int'(word(2)));
    chk("R4 rcs high addr", int'(mem_raddr_o), 3);
    ren_ni = 1'b1; rcs_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R4 ren high dout", int'(dout_o), int'(word(2)));
    chk("R4 ren high addr", int'(mem_raddr_o), 3);
    rcs_ni = 1'b1;
  endtask

  task automatic t_sdr_drain();
    wait_rise();
    ren_ni = 1'b0; rcs_ni = 1'b0;
    repeat (6) @(negedge clk_i);
    chk("R8 drained dout", int'(dout_o), int'(word(5)));
    chk("R8 drained empty", int'(empty_o), 1);
    repeat (4) @(negedge clk_i);
    ren_ni = 1'b1; rcs_ni = 1'b1;
    chk("R8 empty hold dout", int'(dout_o), int'(word(5)));
    chk("R8 empty hold addr", int'(mem_raddr_o), 6);
  endtask

  task automatic t_ddr_pair();
    wr_ptr_i = '0;
    master_reset(1'b1);
    @(negedge clk_i);
    ddr_sel_i = 1'b0;  // after latch point, must be ignored
    chk("R1 empty after reset", int'(empty_o), 1);
    wr_ptr_i = 5'd8;
    wait_rise();
    ren_ni = 1'b0; rcs_ni = 1'b0;
    @(negedge clk_i);
    chk("R5 first word", int'(dout_o), int'(word(0)));
    @(negedge clk_i);
    chk("R2 R5 second word", int'(dout_o), int'(word(1)));
    ren_ni = 1'b1; rcs_ni = 1'b1;
    @(negedge clk_i);
    chk("R5 pair only", int'(dout_o), int'(word(1)));
    chk("R5 addr", int'(mem_raddr_o), 2);
  endtask

  task automatic t_ddr_fall_only();
    wait_rise();
    @(negedge clk_i);  // falling half
    ren_ni = 1'b0; rcs_ni = 1'b0;
    @(negedge clk_i);  // rising half: release before its sample edge
    ren_ni = 1'b1; rcs_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R6 fall enable dout", int'(dout_o), int'(word(1)));
    chk("R6 fall enable addr", int'(mem_raddr_o), 2);
  endtask

  task automatic t_ddr_stream();
    wait_rise();
    ren_ni = 1'b0; rcs_ni = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk("R5 stream even", int'(dout_o), int'(word(2 + 2*k)));
      @(negedge clk_i);
      chk("R5 stream odd", int'(dout_o), int'(word(3 + 2*k)));
      if (k == 2) begin ren_ni = 1'b1; rcs_ni = 1'b1; end
    end
    chk("R5 stream addr", int'(mem_raddr_o), 8);
  endtask

  task automatic t_ddr_last();
    wr_ptr_i = 5'd9;
    wait_rise();
    ren_ni = 1'b0; rcs_ni = 1'b0;
    @(negedge clk_i);
    chk("R7 last word", int'(dout_o), int'(word(8)));
    chk("R7 empty", int'(empty_o), 1);
    ren_ni = 1'b1; rcs_ni = 1'b1;
    @(negedge clk_i);
    chk("R7 no second", int'(dout_o), int'(word(8)));
    chk("R7 addr at wr", int'(mem_raddr_o), 9);
  endtask

  task automatic t_part_reset();
    wr_ptr_i = 5'd12;
    wait_rise();
    part_rst_ni = 1'b0; ren_ni = 1'b0; rcs_ni = 1'b0;
    @(negedge clk_i);
    chk("R9 dout cleared", int'(dout_o), 0);
    chk("R9 addr cleared", int'(mem_raddr_o), 0);
    @(negedge clk_i);
    chk("R9 enables ignored", int'(mem_raddr_o), 0);
    part_rst_ni = 1'b1; ren_ni = 1'b1; rcs_ni = 1'b1;
    wait_rise();
    ren_ni = 1'b0; rcs_ni = 1'b0;
    @(negedge clk_i);
    chk("R9 first after", int'(dout_o), int'(word(0)));
    @(negedge clk_i);
    chk("R9 rate kept", int'(dout_o), int'(word(1)));
    ren_ni = 1'b1; rcs_ni = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = word(i);
    t_reset();
    t_sdr_burst();
    t_gated();
    t_sdr_drain();
    t_ddr_pair();
    t_ddr_fall_only();
    t_ddr_stream();
    t_ddr_last();
    t_part_reset();
    repeat (2) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule